// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block takes a serial HDLC line, sampled one bit per rising edge of its receive clock, and hands the frame content to an 8-bit parallel backend. It locates the flag pattern that opens and closes each frame, removes the zeros that a transmitter inserts after five consecutive ones, recognises the abort sequence, and reports an all-ones idle line once an abort has taken the line out of frame. It does not check the frame check sequence: the FCS bytes reach the backend as ordinary frame bytes. Address filtering, buffering and clock-domain crossing are done elsewhere.

Each delivered byte is a one-cycle strobe. The first byte of a frame carries a start marker. The last byte carries an end marker and a status code, and it also carries a short-frame flag when the frame held fewer bytes than a configured minimum. A frame whose length is not a whole number of bytes is completed with filler bits and not dropped.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 0,1,1,1,1,1,1,0 (a zero, six ones, a zero) is a flag. A flag opens a frame, and the next flag closes it. Frame bits are packed least significant bit first, so the first received bit of a byte lands in `byte_o[0]`. No bit of any flag reaches `byte_o`.
- R2: Inside a frame, a 0 that follows five consecutive 1s is deleted and is not frame data.
- R3: `sof_o` is set only on the first byte of a frame, and `eof_o` only on its last byte. When the frame length is a multiple of 8 bits, the last byte has `status_o` = 2'b00 (good end).
- R4: When a closed frame ends with k bits past a byte boundary (0 < k < 8), the last byte holds those bits in positions 0..k-1 and `FILL_BIT` (default 1) in the positions above them, with `eof_o` set and `status_o` = 2'b10 (misaligned). This byte may follow the byte before it in the very next cycle.
- R5: Seven consecutive 1s are an abort. If the open frame has assembled at least one byte, one final byte is delivered with `eof_o` and `status_o` = 2'b01 (abort), and the bytes before it are the frame's first bytes in order. No further byte is delivered until a new flag.
- R6: Flags that follow each other with no data between them produce no output. One flag may both close a frame and open the next.
- R7: `short_o` is set on a last byte when the frame delivered fewer than `MIN_BYTES` (default 4) bytes in total.
- R8: `idle_o` goes high once an abort has occurred and the line has then shown `IDLE_ONES` (default 15) consecutive 1s with no flag in between. Any 0 clears it. It is never high inside a frame, and never high before the first abort after reset.
- R9: After reset all outputs are 0.
- R10: `sof_o`, `eof_o` and `short_o` are only high together with `byte_vld_o`, and the cycle after an end marker carries no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_i | input | 1 | Serial line data |
| byte_o | output | 8 | Delivered frame byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | Last byte of a frame |
| status_o | output | 2 | End status on `eof_o`: 00 good, 01 abort, 10 misaligned |
| short_o | output | 1 | Frame shorter than `MIN_BYTES`, set on `eof_o` |
| idle_o | output | 1 | Line idle after an abort |

## Verification
The assertions check the following on every cycle. A frame only opens on a received 0. Idle is only reported after a received 1. The padded tail byte never collides with another event. An end marker is always followed by a quiet cycle, and the short flag only appears on an end marker. The bench scenarios are the only evidence for the rest. These are the byte values after zero deletion, the exact placement of filler bits, the alignment of the start and end markers across back-to-back frames, the prefix delivered before an abort, and the idle onset count. The bench drives them from random payloads, and it covers stuffing-heavy, flag-like and sub-byte frames.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        END_GOOD     = 2'b00,
        END_ABORT    = 2'b01,
        END_MISALIGN = 2'b10
    } end_stat_e;

    // Per-bit classification produced by the line detector
    typedef struct packed {
        logic push;        // bit is candidate frame content
        logic dbit;        // value of that bit
        logic flag;        // closing zero of a flag seen
        logic abort;       // seventh consecutive one seen
        logic frame_end;   // flag while a frame is open
        logic frame_abort; // abort while a frame is open
    } line_ev_t;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
        end_stat_e  stat;
        logic       short_f;
    } rx_byte_t;

    // Complete a partial byte of nbits received bits (held in the top bits)
    function automatic logic [7:0] pad_byte(input logic [7:0] part,
                                            input logic [2:0] nbits,
                                            input logic       fill);
        logic [7:0] r;
        r = part;
        for (int i = 0; i < 8; i++) begin
            if (i < 8 - int'(nbits)) r = {fill, r[7:1]};
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_linedet.sv
module hdlc_rx_linedet
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_ONES = 15
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_bit,
    output line_ev_t ev,
    output logic     idle
);
    localparam int OW = $clog2(IDLE_ONES + 1);

    logic [OW-1:0] ones_q;
    logic          in_frame_q;
    logic          seen_abort_q;
    logic          five, six, many;

    always_comb begin
        five           = (ones_q == OW'(5));
        six            = (ones_q == OW'(6));
        many           = (ones_q >= OW'(6));
        ev.dbit        = rx_bit;
        ev.flag        = !rx_bit && six;
        ev.abort       = rx_bit && six;
        ev.frame_end   = in_frame_q && ev.flag;
        ev.frame_abort = in_frame_q && ev.abort;
        ev.push        = in_frame_q && (rx_bit ? !many : !(five || six));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q       <= '0;
            in_frame_q   <= 1'b0;
            seen_abort_q <= 1'b0;
        end else begin
            if (!rx_bit)                       ones_q <= '0;
            else if (ones_q != OW'(IDLE_ONES)) ones_q <= ones_q + 1'b1;
            if (ev.flag) begin
                in_frame_q   <= 1'b1;
                seen_abort_q <= 1'b0;
            end else if (ev.abort) begin
                in_frame_q   <= 1'b0;
                seen_abort_q <= 1'b1;
            end
        end
    end

    assign idle = !in_frame_q && seen_abort_q && (ones_q == OW'(IDLE_ONES));

    // R1: a frame can only open on the closing zero of a flag
    assert_open_on_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame_q) |-> !$past(rx_bit));

    // R8: idle is only reported right after a received one
    assert_idle_after_one_R8: assert property (@(posedge clk) disable iff (rst)
        idle |-> $past(rx_bit));

endmodule

// File: rtl/hdlc_rx_bitdelay.sv
module hdlc_rx_bitdelay #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push,
    input  logic dbit,
    output logic exit_vld,
    output logic exit_bit
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] line_q;
    logic [CW-1:0]    cnt_q;

    assign exit_vld = push && (cnt_q == CW'(DEPTH));
    assign exit_bit = line_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (push) begin
            line_q <= {dbit, line_q[DEPTH-1:1]};
            if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_assemble.sv
module hdlc_rx_assemble
    import hdlc_rx_pkg::*;
#(
    parameter int   MIN_BYTES = 4,
    parameter logic FILL_BIT  = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_vld,
    input  logic     bit_val,
    input  logic     flag,
    input  logic     frame_end,
    input  logic     frame_abort,
    output rx_byte_t out,
    output logic     out_vld
);
    localparam int BW = $clog2(MIN_BYTES + 1);

    logic [7:0]    asm_q, asm_d, held_q, held_d, pad_q, pad_d, nb;
    logic [2:0]    acnt_q, acnt_d;
    logic          held_v_q, held_v_d, sof_pend_q, sof_pend_d;
    logic          pad_pend_q, pad_pend_d, pad_sof_q, pad_sof_d;
    logic [BW-1:0] bcnt_q, bcnt_d, bcnt_inc;
    logic          short_now;
    rx_byte_t      out_q, out_d;
    logic          vld_q, vld_d;

    always_comb begin
        asm_d      = asm_q;
        acnt_d     = acnt_q;
        held_d     = held_q;
        held_v_d   = held_v_q;
        sof_pend_d = sof_pend_q;
        bcnt_d     = bcnt_q;
        pad_pend_d = 1'b0;
        pad_d      = pad_q;
        pad_sof_d  = pad_sof_q;
        out_d      = '0;
        vld_d      = 1'b0;
        nb         = {bit_val, asm_q[7:1]};
        short_now  = (int'(bcnt_q) + 1) < MIN_BYTES;
        bcnt_inc   = (bcnt_q == BW'(MIN_BYTES)) ? bcnt_q : bcnt_q + 1'b1;

        if (pad_pend_q) begin
            vld_d         = 1'b1;
            out_d.data    = pad_q;
            out_d.sof     = pad_sof_q;
            out_d.eof     = 1'b1;
            out_d.stat    = END_MISALIGN;
            out_d.short_f = short_now;
            bcnt_d        = '0;
        end else if (frame_end) begin
            if (acnt_q == 3'd0) begin
                if (held_v_q) begin
                    vld_d         = 1'b1;
                    out_d.data    = held_q;
                    out_d.sof     = sof_pend_q;
                    out_d.eof     = 1'b1;
                    out_d.stat    = END_GOOD;
                    out_d.short_f = short_now;
                end
                bcnt_d = '0;
            end else begin
                if (held_v_q) begin
                    vld_d      = 1'b1;
                    out_d.data = held_q;
                    out_d.sof  = sof_pend_q;
                    bcnt_d     = bcnt_inc;
                    pad_sof_d  = 1'b0;
                end else begin
                    pad_sof_d  = sof_pend_q;
                end
                pad_pend_d = 1'b1;
                pad_d      = pad_byte(asm_q, acnt_q, FILL_BIT);
            end
            held_v_d   = 1'b0;
            acnt_d     = '0;
            sof_pend_d = 1'b1;
        end else if (frame_abort) begin
            if (held_v_q || acnt_q != 3'd0) begin
                vld_d         = 1'b1;
                out_d.data    = held_v_q ? held_q : pad_byte(asm_q, acnt_q, FILL_BIT);
                out_d.sof     = sof_pend_q;
                out_d.eof     = 1'b1;
                out_d.stat    = END_ABORT;
                out_d.short_f = short_now;
            end
            bcnt_d     = '0;
            held_v_d   = 1'b0;
            acnt_d     = '0;
            sof_pend_d = 1'b0;
        end else if (flag) begin
            bcnt_d     = '0;
            held_v_d   = 1'b0;
            acnt_d     = '0;
            sof_pend_d = 1'b1;
        end else if (bit_vld) begin
            if (acnt_q == 3'd7) begin
                if (held_v_q) begin
                    vld_d      = 1'b1;
                    out_d.data = held_q;
                    out_d.sof  = sof_pend_q;
                    sof_pend_d = 1'b0;
                    bcnt_d     = bcnt_inc;
                end
                held_d   = nb;
                held_v_d = 1'b1;
                acnt_d   = '0;
            end else begin
                asm_d  = nb;
                acnt_d = acnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q      <= '0;
            acnt_q     <= '0;
            held_q     <= '0;
            held_v_q   <= 1'b0;
            sof_pend_q <= 1'b0;
            bcnt_q     <= '0;
            pad_pend_q <= 1'b0;
            pad_q      <= '0;
            pad_sof_q  <= 1'b0;
            out_q      <= '0;
            vld_q      <= 1'b0;
        end else begin
            asm_q      <= asm_d;
            acnt_q     <= acnt_d;
            held_q     <= held_d;
            held_v_q   <= held_v_d;
            sof_pend_q <= sof_pend_d;
            bcnt_q     <= bcnt_d;
            pad_pend_q <= pad_pend_d;
            pad_q      <= pad_d;
            pad_sof_q  <= pad_sof_d;
            out_q      <= out_d;
            vld_q      <= vld_d;
        end
    end

    assign out     = out_q;
    assign out_vld = vld_q;

    // R4: the padded tail slot is never contended by line events
    assert_pad_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        pad_pend_q |-> !(bit_vld || flag || frame_end || frame_abort));

    // R10: an end marker is followed by a cycle without a byte
    assert_eof_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (vld_q && out_q.eof) |=> !vld_q);

    // R7: short marking only on a delivered last byte
    assert_short_on_eof_R7: assert property (@(posedge clk) disable iff (rst)
        out_q.short_f |-> (vld_q && out_q.eof));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int   IDLE_ONES = 15,
    parameter int   MIN_BYTES = 4,
    parameter logic FILL_BIT  = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit_i,
    output logic [7:0] byte_o,
    output logic       byte_vld_o,
    output logic       sof_o,
    output logic       eof_o,
    output logic [1:0] status_o,
    output logic       short_o,
    output logic       idle_o
);
    // zero plus six ones of a closing flag enter the content path
    localparam int FLAG_TAIL = 7;

    line_ev_t ev;
    logic     exit_vld, exit_bit;
    rx_byte_t rb;
    logic     rb_vld;

    hdlc_rx_linedet #(.IDLE_ONES(IDLE_ONES)) u_linedet (
        .clk    (clk),
        .rst    (rst),
        .rx_bit (rx_bit_i),
        .ev     (ev),
        .idle   (idle_o)
    );

    hdlc_rx_bitdelay #(.DEPTH(FLAG_TAIL)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .clr      (ev.flag | ev.abort),
        .push     (ev.push),
        .dbit     (ev.dbit),
        .exit_vld (exit_vld),
        .exit_bit (exit_bit)
    );

    hdlc_rx_assemble #(.MIN_BYTES(MIN_BYTES), .FILL_BIT(FILL_BIT)) u_asm (
        .clk         (clk),
        .rst         (rst),
        .bit_vld     (exit_vld),
        .bit_val     (exit_bit),
        .flag        (ev.flag),
        .frame_end   (ev.frame_end),
        .frame_abort (ev.frame_abort),
        .out         (rb),
        .out_vld     (rb_vld)
    );

    assign byte_o     = rb.data;
    assign byte_vld_o = rb_vld;
    assign sof_o      = rb.sof;
    assign eof_o      = rb.eof;
    assign status_o   = rb.stat;
    assign short_o    = rb.short_f;

    // R8: idle never coincides with a delivered byte
    assert_idle_no_byte_R8: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> !byte_vld_o);

endmodule

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;

    localparam int   MINB = 4;
    localparam int   IDLE = 15;
    localparam logic FILL = 1'b1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic [7:0] byte_o;
    logic       byte_vld_o, sof_o, eof_o, short_o, idle_o;
    logic [1:0] status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic       pay [0:255];
    logic [7:0] g_data [$];
    logic       g_sof [$];
    logic       g_eof [$];
    logic [1:0] g_st  [$];
    logic       g_sh  [$];

    always #10 clk = ~clk;

    hdlc_rx_deframer #(.IDLE_ONES(IDLE), .MIN_BYTES(MINB), .FILL_BIT(FILL)) i_hdlc_rx_deframer (
        .clk(clk), .rst(rst), .rx_bit_i(rx_bit), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .sof_o(sof_o), .eof_o(eof_o), .status_o(status_o), .short_o(short_o), .idle_o(idle_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(byte_vld_o || !(sof_o || eof_o || short_o), "R10 marker without byte",
                int'({sof_o, eof_o, short_o}), 0);
            if (byte_vld_o) begin
                g_data.push_back(byte_o);
                g_sof.push_back(sof_o);
                g_eof.push_back(eof_o);
                g_st.push_back(status_o);
                g_sh.push_back(short_o);
            end
        end
    end

    function automatic logic [7:0] exp_byte(input int i, input int n);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[j] = (i * 8 + j < n) ? pay[i * 8 + j] : FILL;
        return r;
    endfunction

    task automatic clear_got();
        g_data.delete(); g_sof.delete(); g_eof.delete(); g_st.delete(); g_sh.delete();
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(negedge clk);
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
    endtask

    task automatic send_payload(input int n);
        int ones;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            send_bit(pay[i]);
            if (pay[i]) begin
                ones++;
                if (ones == 5) begin
                    send_bit(1'b0);
                    ones = 0;
                end
            end else ones = 0;
        end
    endtask

    task automatic check_frame(input int n, input int base, input string tag);
        int nb;
        nb = (n + 7) / 8;
        chk(g_data.size() >= base + nb, {tag, " R1 byte count"}, g_data.size() - base, nb);
        if (g_data.size() < base + nb) return;
        for (int i = 0; i < nb; i++) begin
            chk(g_data[base + i] == exp_byte(i, n), {tag, " R1 R2 data"},
                int'(g_data[base + i]), int'(exp_byte(i, n)));
            chk(g_sof[base + i] == (i == 0), {tag, " R3 sof"}, int'(g_sof[base + i]), int'(i == 0));
            chk(g_eof[base + i] == (i == nb - 1), {tag, " R3 eof"}, int'(g_eof[base + i]), int'(i == nb - 1));
        end
        chk(g_st[base + nb - 1] == ((n % 8 != 0) ? 2'b10 : 2'b00), {tag, " R3 R4 status"},
            int'(g_st[base + nb - 1]), (n % 8 != 0) ? 2 : 0);
        chk(g_sh[base + nb - 1] == (nb < MINB), {tag, " R7 short"}, int'(g_sh[base + nb - 1]), int'(nb < MINB));
    endtask

    task automatic run_good(input int n, input string tag);
        clear_got();
        send_flag();
        chk(idle_o == 1'b0, {tag, " R8 idle in frame"}, int'(idle_o), 0);
        send_payload(n);
        send_flag();
        send_flag();
        check_frame(n, 0, tag);
        chk(g_data.size() == (n + 7) / 8, {tag, " R6 no extra bytes"}, g_data.size(), (n + 7) / 8);
    endtask

    task automatic run_abort(input int n);
        int cnt;
        clear_got();
        send_flag();
        send_payload(n);
        for (int i = 0; i < 7 + IDLE; i++) send_bit(1'b1);
        cnt = g_data.size();
        chk(cnt >= 1, "R5 abort delivers final byte", cnt, 1);
        if (cnt >= 1) begin
            chk(g_eof[cnt - 1] && g_st[cnt - 1] == 2'b01, "R5 abort status",
                int'({g_eof[cnt - 1], g_st[cnt - 1]}), 5);
            for (int i = 0; i < cnt - 1; i++) begin
                chk(g_data[i] == exp_byte(i, n) && !g_eof[i], "R5 abort prefix",
                    int'(g_data[i]), int'(exp_byte(i, n)));
            end
        end
        chk(idle_o == 1'b1, "R8 idle after abort", int'(idle_o), 1);
        send_bit(1'b0);
        chk(idle_o == 1'b0, "R8 zero clears idle", int'(idle_o), 0);
        chk(g_data.size() == cnt, "R5 nothing after abort", g_data.size(), cnt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk({byte_o, byte_vld_o, sof_o, eof_o, status_o, short_o, idle_o} == '0, "R9 reset outputs",
            int'({byte_o, byte_vld_o, sof_o, eof_o, status_o, short_o, idle_o}), 0);
        for (int i = 0; i < 30; i++) send_bit(1'b0);
        chk(idle_o == 1'b0, "R8 no idle before abort", int'(idle_o), 0);

        // R6: back-to-back flags give nothing
        clear_got();
        for (int i = 0; i < 5; i++) send_flag();
        chk(g_data.size() == 0, "R6 empty flags", g_data.size(), 0);

        // R2: stuffing-heavy payload of all ones, 32 bits
        for (int i = 0; i < 32; i++) pay[i] = 1'b1;
        run_good(32, "ones32");
        // R1: payload bytes shaped like flags
        for (int i = 0; i < 24; i++) pay[i] = ((i % 8) != 0 && (i % 8) != 7);
        run_good(24, "flaglike");
        // R4: sub-byte and misaligned frames
        for (int i = 0; i < 64; i++) pay[i] = 1'(i % 3 == 0);
        run_good(3, "len3");
        run_good(13, "len13");
        run_good(41, "len41");
        // R7: boundary around the minimum byte count
        run_good(24, "len24");
        run_good(32, "len32");

        // R6: one flag closes a frame and opens the next
        clear_got();
        for (int i = 0; i < 16; i++) pay[i] = 1'($urandom_range(0, 1));
        send_flag();
        send_payload(16);
        send_flag();
        send_payload(16);
        send_flag();
        send_flag();
        chk(g_data.size() == 4, "R6 shared flag count", g_data.size(), 4);
        check_frame(16, 0, "sharedA");
        check_frame(16, 2, "sharedB");

        // R5 R8 directed abort
        for (int i = 0; i < 40; i++) pay[i] = 1'($urandom_range(0, 1));
        run_abort(40);

        // random frames
        for (int f = 0; f < 40; f++) begin
            n = $urandom_range(1, 80);
            for (int i = 0; i < n; i++) pay[i] = 1'($urandom_range(0, 1));
            if (f % 5 == 4) run_abort((n < 16) ? 16 : n);
            else run_good(n, "random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule